// File: doc/BRIEF.md
# Center-Aligned PWM Channel with Dead Time

This block is one output channel of a timer. It watches an externally generated up/down time-base counter and turns it into a center-aligned pulse on a single pin. A compare value `dutyA` places the two pulse edges symmetrically about the counter peak. A dead-time value `deadB` delays one of the two edges, either the leading (activating) edge or the trailing (deactivating) edge, as selected by `trailMode`. A polarity input chooses whether the active pin level is high or low.

Two force strobes let software-driven logic move the pin at the next clock edge, outside the compare schedule. Force requests act even while the channel is frozen. A delayed edge carries the index of the counter cycle it was scheduled in. If the delay expires on or after the next cycle boundary, the edge is dropped. A long dead time on the trailing edge therefore cannot leak into the following period, and a steady 100% output is possible.

The counter bus is assumed to count 1, 2, … up to its peak with `cntUp` high, then down to 0 with `cntUp` low. `cycleStart` is high on the tick where the counter reads 1 while counting up.

Top module: `cpwm_top`

## Requirements
- R1: In reset, and afterwards until the first activating event, the pin is at the idle level, which is the inverse of `polHigh`. Whenever the channel is active, the pin equals `polHigh`.
- R2: With `trailMode`=1, a clock edge that samples `cntVal`==`dutyA` with `cntUp`=1 makes the pin active right after that edge.
- R3: With `trailMode`=1, a clock edge that samples `cntVal`==`dutyA` with `cntUp`=0 makes the pin idle `deadB` edges later. With `deadB`=0 it goes idle at that same edge.
- R4: With `trailMode`=0, the up-count match makes the pin active `deadB` edges later, and the down-count match makes it idle at that same edge.
- R5: A delayed edge is discarded if its expiry edge samples `cycleStart`=1 or lies in a later cycle. For example, with a peak of 8, `dutyA`=2 and `deadB`=3 in trailing mode, the pin stays active for the whole period.
- R6: With `dutyA`=1 in trailing mode, `deadB`>=2 gives 100% active output. `deadB`=1 leaves the pin idle only on the tick where the counter reads 0.
- R7: With `dutyA` above the counter peak, no edge is produced and a pin that starts idle stays idle (0% duty).
- R8: With `dutyA` equal to the counter peak, the pin stays active once the first up-count match has occurred.
- R9: `forceA` and `forceB` asserted together make the pin idle at the next edge, in both dead-time modes.
- R10: `forceA` alone makes the pin active in trailing mode and idle in leading mode. `forceB` alone does the opposite. The effect appears at the next edge.
- R11: While `freeze`=1, counter matches and dead-time counting are suspended and the pin holds its level, but the force strobes still act as in R9 and R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cntVal | input | CW | Time-base counter value |
| cntUp | input | 1 | Counter direction, 1 = counting up |
| cycleStart | input | 1 | High on the tick that opens a new counter cycle |
| dutyA | input | CW | Compare value placing both pulse edges |
| deadB | input | CW | Dead-time length in clock edges |
| polHigh | input | 1 | Active pin level |
| trailMode | input | 1 | 1 = delay trailing edge, 0 = delay leading edge |
| freeze | input | 1 | Suspend compare and dead-time logic |
| forceA | input | 1 | Force strobe A |
| forceB | input | 1 | Force strobe B |
| pinOut | output | 1 | PWM pin level |

## Verification
The assertions assume that `trailMode` does not change in the cycle after a force strobe or a counter match. They also assume that the counter bus follows the up-then-down order, with `cycleStart` only on the up-count value 1. The stimulus changes mode, polarity and compare settings only between scenarios, and then runs a full warm-up period before any sampled period. All counter values come from one model sequence that follows these rules. Forces are applied with the counter parked at a value that matches nothing.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef struct packed {
    logic goActive;
    logic goIdle;
  } edgeStrb_t;
endpackage

// File: rtl/cpwm_ctrl.sv
module cpwm_ctrl #(
  parameter int CW = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 freeze,
  input  logic                 trailMode,
  input  logic [CW-1:0]        cntVal,
  input  logic                 cntUp,
  input  logic                 cycleStart,
  input  logic [CW-1:0]        dutyA,
  input  logic [CW-1:0]        deadB,
  input  logic                 anyForce,
  output cpwm_pkg::edgeStrb_t  strb
);
  logic          cycPar;
  logic          curCycle;
  logic [CW-1:0] pendCnt;
  logic          pendTag;
  logic          hit;
  logic          immHit;
  logic          dlyHit;
  logic          fireOk;

  // cycle index as seen by this edge: a boundary tick already belongs to the new cycle
  assign curCycle = cycleStart ? ~cycPar : cycPar;
  assign hit      = (cntVal == dutyA);
  assign immHit   = hit && (trailMode ? cntUp : !cntUp);
  assign dlyHit   = hit && (trailMode ? !cntUp : cntUp);
  assign fireOk   = (pendCnt == CW'(1)) && (pendTag == curCycle);

  always_comb begin
    strb = '0;
    if (!freeze) begin
      if (immHit) begin
        strb.goActive = trailMode;
        strb.goIdle   = !trailMode;
      end else if ((dlyHit && (deadB == '0)) || fireOk) begin
        strb.goActive = !trailMode;
        strb.goIdle   = trailMode;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycPar  <= 1'b0;
      pendCnt <= '0;
      pendTag <= 1'b0;
    end else if (anyForce) begin
      pendCnt <= '0;
      if (!freeze && cycleStart) cycPar <= ~cycPar;
    end else if (!freeze) begin
      if (cycleStart) cycPar <= ~cycPar;
      if (immHit) begin
        pendCnt <= '0;
      end else if (dlyHit && (deadB != '0)) begin
        pendCnt <= deadB;
        pendTag <= curCycle;
      end else if (pendCnt != '0) begin
        pendCnt <= pendCnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/cpwm_dp.sv
module cpwm_dp (
  input  logic                clk,
  input  logic                rstN,
  input  cpwm_pkg::edgeStrb_t strb,
  input  logic                forceA,
  input  logic                forceB,
  input  logic                trailMode,
  input  logic                polHigh,
  output logic                activeLvl,
  output logic                pinOut
);
  logic nxtActive;

  always_comb begin
    if (forceA && forceB)  nxtActive = 1'b0;
    else if (forceA)       nxtActive = trailMode;
    else if (forceB)       nxtActive = !trailMode;
    else if (strb.goActive) nxtActive = 1'b1;
    else if (strb.goIdle)  nxtActive = 1'b0;
    else                   nxtActive = activeLvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) activeLvl <= 1'b0;
    else       activeLvl <= nxtActive;
  end

  assign pinOut = ~(activeLvl ^ polHigh);
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] cntVal,
  input  logic          cntUp,
  input  logic          cycleStart,
  input  logic [CW-1:0] dutyA,
  input  logic [CW-1:0] deadB,
  input  logic          polHigh,
  input  logic          trailMode,
  input  logic          freeze,
  input  logic          forceA,
  input  logic          forceB,
  output logic          pinOut
);
  cpwm_pkg::edgeStrb_t strb;
  logic activeLvl;

  cpwm_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .freeze(freeze), .trailMode(trailMode),
    .cntVal(cntVal), .cntUp(cntUp), .cycleStart(cycleStart),
    .dutyA(dutyA), .deadB(deadB), .anyForce(forceA | forceB), .strb(strb)
  );

  cpwm_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .forceA(forceA), .forceB(forceB),
    .trailMode(trailMode), .polHigh(polHigh), .activeLvl(activeLvl), .pinOut(pinOut)
  );
endmodule

// File: rtl/cpwm_chk.sv
module cpwm_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          freeze,
  input logic          trailMode,
  input logic          cntUp,
  input logic [CW-1:0] cntVal,
  input logic [CW-1:0] dutyA,
  input logic          forceA,
  input logic          forceB,
  input logic          activeLvl
);
  p_both_force_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (forceA && forceB) |=> !activeLvl);

  p_force_a_level_r10: assert property (@(posedge clk) disable iff (!rstN)
    (forceA && !forceB) |=> (activeLvl == $past(trailMode)));

  p_force_b_level_r10: assert property (@(posedge clk) disable iff (!rstN)
    (forceB && !forceA) |=> (activeLvl == !$past(trailMode)));

  p_freeze_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (freeze && !forceA && !forceB) |=> $stable(activeLvl));

  p_trail_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!freeze && !forceA && !forceB && trailMode && cntUp && cntVal == dutyA) |=> activeLvl);

  p_lead_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!freeze && !forceA && !forceB && !trailMode && !cntUp && cntVal == dutyA) |=> !activeLvl);
endmodule

bind cpwm_top cpwm_chk #(.CW(CW)) u_chk (.*);

// File: tb/cpwm_top_test.sv
module cpwm_top_test;
  localparam int CW = 8;
  localparam int PEAK = 8;
  localparam int TICKS = 2 * PEAK;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [CW-1:0] cntVal = '0;
  logic          cntUp = 1'b0;
  logic          cycleStart = 1'b0;
  logic [CW-1:0] dutyA = 8'd3;
  logic [CW-1:0] deadB = '0;
  logic          polHigh = 1'b1;
  logic          trailMode = 1'b1;
  logic          freeze = 1'b0;
  logic          forceA = 1'b0;
  logic          forceB = 1'b0;
  logic          pinOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  cpwm_top #(.CW(CW)) uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] span(input int lo, input int hi);
    logic [15:0] m = '0;
    for (int i = lo; i <= hi; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic doReset();
    rstN = 1'b0; forceA = 0; forceB = 0; freeze = 0;
    cntVal = '0; cntUp = 0; cycleStart = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // one counter period; bit i = channel active right after the edge of tick i
  task automatic runCycle(output logic [15:0] act);
    act = '0;
    for (int i = 0; i < TICKS; i++) begin
      cntVal = (i < PEAK) ? CW'(i + 1) : CW'(TICKS - 1 - i);
      cntUp = (i < PEAK);
      cycleStart = (i == 0);
      @(negedge clk);
      act[i] = (pinOut == polHigh);
    end
    cntVal = '0; cntUp = 0; cycleStart = 0;
  endtask

  task automatic setup(input logic pol, input logic trl, input int a, input int b);
    polHigh = pol; trailMode = trl; dutyA = CW'(a); deadB = CW'(b);
  endtask

  task automatic forceTick(input logic a, input logic b);
    forceA = a; forceB = b;
    @(negedge clk);
    forceA = 0; forceB = 0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    polHigh = 1'b1;
    @(negedge clk);
    chk("R1 idle pin pol=1", {15'b0, pinOut}, 16'h0000);
    polHigh = 1'b0;
    #1;
    chk("R1 idle pin pol=0", {15'b0, pinOut}, 16'h0001);
    doReset();
  endtask

  task automatic testTrail();
    logic [15:0] w, s;
    setup(1'b1, 1'b1, 3, 2);
    runCycle(w); runCycle(s);
    chk("R2 R3 trail a=3 b=2", s, span(2, 13));
    setup(1'b1, 1'b1, 3, 0);
    runCycle(w); runCycle(s);
    chk("R3 trail b=0", s, span(2, 11));
  endtask

  task automatic testLead();
    logic [15:0] w, s;
    setup(1'b0, 1'b0, 3, 2);
    runCycle(w); runCycle(s);
    chk("R4 R1 lead a=3 b=2 pol=0", s, span(4, 11));
  endtask

  task automatic testCrossing();
    logic [15:0] w, s;
    setup(1'b1, 1'b1, 2, 3);
    runCycle(w); runCycle(s);
    chk("R5 expiry on boundary dropped", s, 16'hFFFF);
    setup(1'b1, 1'b1, 2, 2);
    runCycle(w); runCycle(s);
    chk("R5 expiry before boundary kept", s, span(1, 14));
  endtask

  task automatic testDutyOne();
    logic [15:0] w, s;
    setup(1'b1, 1'b1, 1, 2);
    runCycle(w); runCycle(s);
    chk("R6 a=1 b=2 full duty", s, 16'hFFFF);
    setup(1'b1, 1'b1, 1, 1);
    runCycle(w); runCycle(s);
    chk("R6 a=1 b=1 idle at count 0", s, span(0, 14));
  endtask

  task automatic testAboveAndPeak();
    logic [15:0] w, s;
    doReset();
    setup(1'b1, 1'b1, PEAK + 1, 2);
    runCycle(w); runCycle(s);
    chk("R7 above peak zero duty", s | w, 16'h0000);
    setup(1'b1, 1'b1, PEAK, 2);
    runCycle(w); runCycle(s);
    chk("R8 equal peak steady active", s, 16'hFFFF);
  endtask

  task automatic testFreezeForce();
    doReset();
    setup(1'b1, 1'b1, 3, 0);
    freeze = 1'b1;
    cntVal = 8'd3; cntUp = 1'b1;
    @(negedge clk);
    cntVal = '0; cntUp = 1'b0;
    chk("R11 frozen match ignored", {15'b0, pinOut}, 16'h0000);
    forceTick(1, 0);
    chk("R11 R10 trail forceA active", {15'b0, pinOut}, 16'h0001);
    forceTick(0, 1);
    chk("R10 trail forceB idle", {15'b0, pinOut}, 16'h0000);
    forceTick(1, 0);
    forceTick(1, 1);
    chk("R9 trail both forces idle", {15'b0, pinOut}, 16'h0000);
    trailMode = 1'b0;
    forceTick(0, 1);
    chk("R10 lead forceB active", {15'b0, pinOut}, 16'h0001);
    forceTick(1, 0);
    chk("R10 lead forceA idle", {15'b0, pinOut}, 16'h0000);
    forceTick(0, 1);
    forceTick(1, 1);
    chk("R9 lead both forces idle", {15'b0, pinOut}, 16'h0000);
    freeze = 1'b0;
    trailMode = 1'b1;
    forceTick(1, 0);
    chk("R10 unfrozen forceA active", {15'b0, pinOut}, 16'h0001);
  endtask

  initial begin
    testReset();
    testTrail();
    testLead();
    testCrossing();
    testDutyOne();
    testAboveAndPeak();
    testFreezeForce();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule